// File: doc/BRIEF.md
# Phase Ramp Accumulator

This block turns a per-sample angle step into a continuously wrapping angle ramp. It is the angle reference for open-loop (volts-per-hertz) or field-oriented motor control. On every sample strobe the step is added to a phase register. The sum is then folded back into one electrical revolution, so the ramp repeats at the frequency the step stands for. Steps of either sign are accepted, which lets the ramp run in reverse.

The angle unit is fixed at build time: per-unit, radians or degrees. Both the step and the phase use that unit, in a signed fixed-point format with `FRAC_W` fraction bits. A build parameter gives the start-up phase. A synchronous, active-high clear input can be set at build time to do one of three things: nothing, load zero, or load the start-up phase. The phase output is registered.

Top module: `phase_ramp_gen`

## Requirements
- R1: While `rst_n` is low, the phase register loads `INIT_PHASE`, whatever `CLR_MODE` is set to.
- R2: When `sample_en` is high and no clear applies, `phase` shows the wrapped value of the old phase plus `phase_step` after the next rising clock edge, which is one cycle of latency.
- R3: If the raw sum is at or above the modulus, the modulus is subtracted once. A sum exactly equal to the modulus therefore gives 0.
- R4: If the raw sum is negative, the modulus is added once. For example, 0 plus a step of -1 LSB gives the modulus minus 1 LSB.
- R5: When `sample_en` is low and no clear applies, `phase` keeps its value.
- R6: The modulus in LSBs depends on `UNIT`: 2^FRAC_W for per-unit, round(2π·2^FRAC_W) for radians and 360·2^FRAC_W for degrees. The word is one sign bit, then 2, 4 or 10 integer bits for those units, then FRAC_W fraction bits. With FRAC_W=16 this gives widths of 19, 21 and 27 bits.
- R7: With `CLR_MODE` = CLR_NONE, `sync_clr` has no effect on `phase`.
- R8: With `CLR_MODE` = CLR_ZERO, a high `sync_clr` makes `phase` 0 after the next edge.
- R9: With `CLR_MODE` = CLR_INIT, a high `sync_clr` makes `phase` equal `INIT_PHASE` after the next edge.
- R10: A clear that applies wins over `sample_en` in the same cycle.
- R11: For steps smaller in magnitude than the modulus, `phase` always stays in the range [0, modulus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| sample_en | input | 1 | Sample strobe; the step is accumulated when this is high |
| sync_clr | input | 1 | Active-high synchronous clear; its effect is set by CLR_MODE |
| phase_step | input | W | Signed per-sample angle step |
| phase | output | W | Signed wrapped phase, registered |

## Verification
The bench drives three copies of the block, one per unit, and each copy has a different clear mode. Directed steps hit the top edge exactly: a sum equal to the modulus must read 0. A design that compares with "greater than" instead of "at or above" would show the modulus itself. A step of -1 from zero must read modulus-minus-one; a design that drops the negative fold would show a negative phase. The bench also raises the clear together with the strobe, which catches a mux with the wrong priority, and raises the clear on the copy whose mode ignores it. Random signed steps of up to nearly one modulus then check repeated wrapping in both directions against a bench model.

// File: rtl/phase_pkg.sv
package phase_pkg;

   typedef enum int {ANG_PU = 0, ANG_RAD = 1, ANG_DEG = 2} angle_unit_e;
   typedef enum int {CLR_NONE = 0, CLR_ZERO = 1, CLR_INIT = 2} clr_mode_e;

   // integer bits needed to hold up to twice one revolution
   function automatic int int_bits(angle_unit_e u);
      case (u)
         ANG_PU:  return 2;
         ANG_RAD: return 4;
         default: return 10;
      endcase
   endfunction

   // one revolution in LSBs of the fixed-point word
   function automatic longint rev_lsb(angle_unit_e u, int frac);
      case (u)
         ANG_PU:  return longint'(1) <<< frac;
         ANG_RAD: return longint'(6.283185307179586 * (2.0 ** frac));
         default: return longint'(360) <<< frac;
      endcase
   endfunction

endpackage

// File: rtl/phase_wrap_step.sv
module phase_wrap_step #(
   parameter int     W   = 19,
   parameter longint MOD = 65536
) (
   input  logic signed [W-1:0] cur,
   input  logic signed [W-1:0] step,
   output logic signed [W-1:0] nxt
);
   localparam logic signed [W-1:0] MOD_Q = W'(MOD);

   logic signed [W-1:0] raw;

   always_comb begin
      raw = cur + step;
      if (raw >= MOD_Q)   nxt = raw - MOD_Q;
      else if (raw[W-1])  nxt = raw + MOD_Q;
      else                nxt = raw;
   end

   // R11: a wrapped result from in-range operands stays in range
   always_comb begin
      if (!cur[W-1] && cur < MOD_Q && step > -MOD_Q && step < MOD_Q)
         a_wrap_range_r11: assert (!nxt[W-1] && nxt < MOD_Q);
   end
endmodule

// File: rtl/phase_hold_reg.sv
module phase_hold_reg #(
   parameter int W = 19
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] init_val,
   input  logic                clr_hit,
   input  logic signed [W-1:0] clr_val,
   input  logic                load_en,
   input  logic signed [W-1:0] nxt,
   output logic signed [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)        q <= init_val;
      else if (clr_hit)  q <= clr_val;
      else if (load_en)  q <= nxt;
   end

   // R5: no strobe and no clear leaves the register untouched
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !clr_hit) |=> $stable(q));

   // R10: clear wins over a simultaneous strobe
   p_clr_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && load_en) |=> (q == $past(clr_val)));
endmodule

// File: rtl/phase_ramp_gen.sv
module phase_ramp_gen #(
   parameter int                       FRAC_W     = 16,
   parameter phase_pkg::angle_unit_e   UNIT       = phase_pkg::ANG_PU,
   parameter phase_pkg::clr_mode_e     CLR_MODE   = phase_pkg::CLR_NONE,
   parameter longint                   INIT_PHASE = 0,
   localparam int                      INT_W      = phase_pkg::int_bits(UNIT),
   localparam int                      W          = 1 + INT_W + FRAC_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_en,
   input  logic                sync_clr,
   input  logic signed [W-1:0] phase_step,
   output logic signed [W-1:0] phase
);
   localparam longint MOD = phase_pkg::rev_lsb(UNIT, FRAC_W);
   localparam logic signed [W-1:0] MOD_Q  = W'(MOD);
   localparam logic signed [W-1:0] INIT_Q = W'(INIT_PHASE);

   // elaboration-time parameter checks
   if (FRAC_W < 4 || FRAC_W > 24) begin : g_bad_frac
      $error("FRAC_W must lie in 4..24");
   end
   if (INIT_PHASE < 0 || INIT_PHASE >= MOD) begin : g_bad_init
      $error("INIT_PHASE must lie in [0, one revolution)");
   end

   logic                clr_hit;
   logic signed [W-1:0] clr_val;
   logic signed [W-1:0] nxt;

   // clear variant chosen by build mode
   if (CLR_MODE == phase_pkg::CLR_ZERO) begin : g_clr_zero
      assign clr_hit = sync_clr;
      assign clr_val = '0;
      // R8
      p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         sync_clr |=> (phase == '0));
   end else if (CLR_MODE == phase_pkg::CLR_INIT) begin : g_clr_init
      assign clr_hit = sync_clr;
      assign clr_val = INIT_Q;
      // R9
      p_clr_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
         sync_clr |=> (phase == INIT_Q));
   end else begin : g_clr_none
      assign clr_hit = 1'b0;
      assign clr_val = INIT_Q;
      // R7: clear input is ignored; with no strobe the phase holds
      p_clr_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (sync_clr && !sample_en) |=> $stable(phase));
   end

   phase_wrap_step #(.W(W), .MOD(MOD)) u_wrap (
      .cur  (phase),
      .step (phase_step),
      .nxt  (nxt)
   );

   phase_hold_reg #(.W(W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_val (INIT_Q),
      .clr_hit  (clr_hit),
      .clr_val  (clr_val),
      .load_en  (sample_en),
      .nxt      (nxt),
      .q        (phase)
   );

   // R11: output kept inside one revolution
   p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase[W-1] && phase < MOD_Q));

   // R1: power-on reset loads the start-up phase
   p_por_r1: assert property (@(posedge clk)
      !rst_n |=> (phase == INIT_Q));
endmodule

// File: tb/phase_ramp_gen_test.sv
module phase_ramp_gen_test;
   localparam int CLK_PERIOD = 10;

   localparam longint M_PU  = 65536;
   localparam longint M_RAD = 411775;
   localparam longint M_DEG = 23592960;
   localparam longint I_RAD = 65536;
   localparam longint I_DEG = 5898240;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic clr = 1'b0;
   logic signed [18:0] st_pu = '0, ph_pu;
   logic signed [20:0] st_rad = '0, ph_rad;
   logic signed [26:0] st_deg = '0, ph_deg;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   longint e_pu, e_rad, e_deg;

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_ramp_gen #(.FRAC_W(16), .UNIT(phase_pkg::ANG_PU),
                    .CLR_MODE(phase_pkg::CLR_NONE), .INIT_PHASE(0)) uut (
      .clk(clk), .rst_n(rst_n), .sample_en(en), .sync_clr(clr),
      .phase_step(st_pu), .phase(ph_pu));

   phase_ramp_gen #(.FRAC_W(16), .UNIT(phase_pkg::ANG_RAD),
                    .CLR_MODE(phase_pkg::CLR_ZERO), .INIT_PHASE(I_RAD)) u_rad (
      .clk(clk), .rst_n(rst_n), .sample_en(en), .sync_clr(clr),
      .phase_step(st_rad), .phase(ph_rad));

   phase_ramp_gen #(.FRAC_W(16), .UNIT(phase_pkg::ANG_DEG),
                    .CLR_MODE(phase_pkg::CLR_INIT), .INIT_PHASE(I_DEG)) u_deg (
      .clk(clk), .rst_n(rst_n), .sample_en(en), .sync_clr(clr),
      .phase_step(st_deg), .phase(ph_deg));

   function automatic longint mwrap(longint v, longint m);
      if (v >= m) return v - m;
      if (v < 0)  return v + m;
      return v;
   endfunction

   function automatic longint rnd_step(longint m);
      return longint'($urandom % 32'(2*m - 1)) - (m - 1);
   endfunction

   task automatic chk(longint got, longint exp, string tag);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(longint'(ph_pu),  e_pu,  {tag, " pu"});
      chk(longint'(ph_rad), e_rad, {tag, " rad"});
      chk(longint'(ph_deg), e_deg, {tag, " deg"});
   endtask

   // called at a falling edge; drives inputs, advances model, checks next falling edge
   task automatic cycle(bit e, bit c, longint sp, longint sr, longint sd, string tag);
      en = e; clr = c;
      st_pu = 19'(sp); st_rad = 21'(sr); st_deg = 27'(sd);
      if (e) e_pu = mwrap(e_pu + sp, M_PU);                 // R7: clear ignored
      e_rad = c ? 0     : (e ? mwrap(e_rad + sr, M_RAD) : e_rad);
      e_deg = c ? I_DEG : (e ? mwrap(e_deg + sd, M_DEG) : e_deg);
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      e_pu = 0; e_rad = I_RAD; e_deg = I_DEG;
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      // reset with clear high as well: still loads initial phase
      clr = 1'b1;
      @(negedge clk);
      check_all("R1 reset with clear");
      clr = 1'b0; rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");

      cycle(1, 0, 32768, 0, 0, "R2 advance");
      cycle(1, 0, 32768, M_RAD - I_RAD, M_DEG - I_DEG, "R3 R6 exact modulus");
      cycle(1, 0, -1, -1, -1, "R4 negative fold");
      cycle(0, 0, 1000, 2000, 3000, "R5 hold");
      cycle(1, 1, 100, 100, 100, "R7 R8 R9 R10 clear with strobe");
      cycle(0, 1, 5, 5, 5, "R7 R8 R9 clear no strobe");
      cycle(1, 0, M_PU - 1, M_RAD - 1, M_DEG - 1, "R2 R3 large step");
      cycle(1, 0, -(M_PU - 1), -(M_RAD - 1), -(M_DEG - 1), "R4 large negative");

      for (int i = 0; i < 3000; i++) begin
         bit e, c;
         e = ($urandom % 4) != 0;
         c = ($urandom % 16) == 0;
         cycle(e, c, rnd_step(M_PU), rnd_step(M_RAD), rnd_step(M_DEG),
               "R2 R3 R4 R11 random");
         n_chk++;
         if (ph_pu < 0 || longint'(ph_pu) >= M_PU ||
             ph_rad < 0 || longint'(ph_rad) >= M_RAD ||
             ph_deg < 0 || longint'(ph_deg) >= M_DEG) begin
            n_bad++;
            $display("FAIL R11 range: got %0d/%0d/%0d expected below %0d/%0d/%0d",
                     ph_pu, ph_rad, ph_deg, M_PU, M_RAD, M_DEG);
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule